// File: doc/BRIEF.md
# Parallel Camera Input Conditioner

This block sits right behind the pins of a parallel camera port and runs on the pixel clock. It takes raw pixel data, a data-enable pin, a line sync and a frame sync. It delivers enable and sync signals in active-high form, and a 16-bit word with a one-clock valid strobe for each completed pixel word. The sensor may deliver one byte per clock, in which case consecutive bytes are paired into words, or two bytes per clock. An optional byte swap fixes the endianness of the word. A six-bit image data-type tag rides along with every word.

A 32-bit configuration word controls the block. It is written through a simple write strobe and read back at any time. The block stages every write and applies it only when the conditioned frame sync rises, so settings never change in the middle of a frame. The frame sync can go through a deglitch filter whose length is programmable. The filter ignores short bounces that would otherwise start a false frame.

The configuration fields are:
- bit 0: byte swap
- bit 1: two bytes per clock
- bits 7:2: type tag
- bit 8: invert data enable
- bit 9: invert line sync
- bit 10: invert frame sync
- bits 13:11: filter length T
- bit 14: filter enable

Top module: `cam_input_cond`

## Requirements
- R1: After reset the readback is 0x000000A8. The forwarded type tag is 0x2A. No valid strobe is raised.
- R2: A written word, all 32 bits, appears on the readback one clock after the write.
- R3: A written configuration has no effect on the data path, the tag or the sync handling until the conditioned frame sync next rises. On that rising edge the latest written value becomes active. A write made in that same cycle waits for the next rise.
- R4: The data-enable output equals the data-enable pin XOR bit 8, two clocks after the pin. The line-sync output equals the line-sync pin XOR bit 9, two clocks after the pin.
- R5: With bit 14 clear, the frame-sync output equals the frame-sync pin XOR bit 10, two clocks after the pin.
- R6: With bit 14 set and length T in bits 13:11, the frame-sync output takes a new level only after the corrected pin has held that level for T+1 consecutive clocks. Any shorter excursion is suppressed. For T=0 the latency is two clocks, the same as unfiltered.
- R7: With bit 1 set, every clock with corrected enable active yields a valid word equal to the 16-bit input, two clocks later. The output word holds its value between valid strobes.
- R8: With bit 1 clear, successive enabled bytes taken from input bits 7:0 are paired. The first byte of a pair forms the upper half. The valid strobe rises two clocks after the second byte. A lone byte left when enable drops is discarded.
- R9: With bit 0 set, the two halves of each assembled word are exchanged before output.
- R10: The valid strobe is never high unless the data-enable output is high in the same cycle.
- R11: The type tag output always equals bits 7:2 of the active configuration, including codes other than 0x2A, 0x2B and 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration value to write |
| cfgRdData | output | 32 | Last written configuration value |
| pixData | input | 16 | Raw pixel data pins |
| pixDe | input | 1 | Raw data-enable pin |
| pixHsync | input | 1 | Raw line-sync pin |
| pixVsync | input | 1 | Raw frame-sync pin |
| outData | output | 16 | Ordered pixel word |
| outValid | output | 1 | One clock per completed word |
| outType | output | 6 | Active image data-type tag |
| outDe | output | 1 | Active-high data enable |
| outHsync | output | 1 | Active-high line sync |
| outVsync | output | 1 | Conditioned frame sync |

## Verification
A configuration commit and a polarity change on the live enable can land in the same clock. When the rising frame sync activates a word that flips the enable inversion, the corrected enable toggles on the next clock even though the pin did not move. Half-built byte pairs and valid strobes must then follow the new polarity. The bench provokes this by committing configurations that change the enable and frame-sync inversions while the pins stay idle. It judges every cycle that follows against a cycle-level model built from the requirements. In the same way it runs frame-sync bounces one clock shorter and exactly as long as the filter threshold. In those runs a filtered edge can itself trigger a commit.

// File: rtl/cam_cond_pkg.sv
package cam_cond_pkg;

  localparam int CFG_W      = 32;
  localparam int TAG_W      = 6;
  localparam int FILT_W     = 3;
  localparam int CFG_USED   = 15;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_00A8;

  // Field order follows the configuration bit positions, MSB first.
  typedef struct packed {
    logic              filtEn;   // bit 14
    logic [FILT_W-1:0] filtLen;  // bits 13:11
    logic              vsInv;    // bit 10
    logic              hsInv;    // bit 9
    logic              deInv;    // bit 8
    logic [TAG_W-1:0]  tag;      // bits 7:2
    logic              twoByte;  // bit 1
    logic              swap;     // bit 0
  } camCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadHigh;
    logic emitWord;
    logic twoByte;
    logic swap;
  } camStrobe_t;

endpackage

// File: rtl/camCtrl.sv
module camCtrl
  import cam_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              pinDe,
  input  logic              pinHsync,
  input  logic              pinVsync,
  output camStrobe_t        strobe,
  output logic              outDe,
  output logic              outHsync,
  output logic              outVsync,
  output logic [TAG_W-1:0]  outType
);

  logic [CFG_W-1:0]    cfgShadow;
  logic [CFG_USED-1:0] actBits;
  camCfg_t             act;
  logic deS1, hsS1, vsS1, deS2, hsS2, vsS2;
  logic vsFilt, vsPrev, pending, vsRise;
  logic [FILT_W-1:0] filtCnt;

  assign act       = camCfg_t'(actBits);
  assign cfgRdData = cfgShadow;
  assign outType   = act.tag;
  assign outDe     = deS2;
  assign outHsync  = hsS2;
  assign outVsync  = act.filtEn ? vsFilt : vsS2;
  assign vsRise    = outVsync & ~vsPrev;

  assign strobe.emitWord = deS1 & (act.twoByte | pending);
  assign strobe.loadHigh = deS1 & ~act.twoByte & ~pending;
  assign strobe.twoByte  = act.twoByte;
  assign strobe.swap     = act.swap;

  // Configuration staging, input conditioning and byte-pair tracking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgShadow <= CFG_RESET;
      actBits   <= CFG_RESET[CFG_USED-1:0];
      {deS1, hsS1, vsS1, deS2, hsS2, vsS2} <= '0;
      vsPrev    <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (cfgWrEn) cfgShadow <= cfgWrData;
      if (vsRise)  actBits   <= cfgShadow[CFG_USED-1:0];
      deS1    <= pinDe    ^ act.deInv;
      hsS1    <= pinHsync ^ act.hsInv;
      vsS1    <= pinVsync ^ act.vsInv;
      deS2    <= deS1;
      hsS2    <= hsS1;
      vsS2    <= vsS1;
      vsPrev  <= outVsync;
      pending <= strobe.loadHigh;
    end
  end

  // Frame-sync deglitch: new level must persist filtLen+1 samples.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsFilt  <= 1'b0;
      filtCnt <= '0;
    end else if (!act.filtEn) begin
      vsFilt  <= vsS1;
      filtCnt <= '0;
    end else if (vsS1 == vsFilt) begin
      filtCnt <= '0;
    end else if (filtCnt >= act.filtLen) begin
      vsFilt  <= vsS1;
      filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrEn |=> cfgRdData == $past(cfgWrData));

  assert_commit_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actBits) |-> $past(vsRise));

  assert_filter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsFilt) |-> (!$past(act.filtEn) || $past(filtCnt) >= $past(act.filtLen)));

  assert_pair_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.emitWord && !act.twoByte) |=> (!strobe.emitWord || act.twoByte));

endmodule

// File: rtl/camDatapath.sv
module camDatapath
  import cam_cond_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pinData,
  input  camStrobe_t        strobe,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);

  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] dataS1, word, ordered;
  logic [BYTE_W-1:0] hiByte;

  assign word    = strobe.twoByte ? dataS1 : {hiByte, dataS1[BYTE_W-1:0]};
  assign ordered = strobe.swap ? {word[BYTE_W-1:0], word[DATA_W-1:BYTE_W]} : word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataS1   <= '0;
      hiByte   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      dataS1   <= pinData;
      outValid <= strobe.emitWord;
      if (strobe.loadHigh) hiByte  <= dataS1[BYTE_W-1:0];
      if (strobe.emitWord) outData <= ordered;
    end
  end

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.emitWord |=> $stable(outData));

endmodule

// File: rtl/cam_input_cond.sv
module cam_input_cond
  import cam_cond_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixDe,
  input  logic              pixHsync,
  input  logic              pixVsync,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic [TAG_W-1:0]  outType,
  output logic              outDe,
  output logic              outHsync,
  output logic              outVsync
);

  camStrobe_t strobe;

  camCtrl uCtrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .pinDe(pixDe), .pinHsync(pixHsync), .pinVsync(pixVsync),
    .strobe(strobe),
    .outDe(outDe), .outHsync(outHsync), .outVsync(outVsync), .outType(outType)
  );

  camDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst_n(rst_n),
    .pinData(pixData), .strobe(strobe),
    .outData(outData), .outValid(outValid)
  );

  assert_valid_in_de_R10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outDe);

endmodule

// File: tb/cam_input_cond_test.sv
module cam_input_cond_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [15:0] pixData = '0;
  logic pixDe = 1'b0, pixHsync = 1'b0, pixVsync = 1'b0;
  logic [31:0] cfgRdData;
  logic [15:0] outData;
  logic outValid, outDe, outHsync, outVsync;
  logic [5:0] outType;

  always #5 clk = ~clk;

  cam_input_cond uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .pixData(pixData), .pixDe(pixDe),
    .pixHsync(pixHsync), .pixVsync(pixVsync), .outData(outData),
    .outValid(outValid), .outType(outType), .outDe(outDe),
    .outHsync(outHsync), .outVsync(outVsync)
  );

  int nChk = 0, nErr = 0;
  bit ended = 1'b0;

  // Cycle-level reference built from the requirements.
  logic [31:0] mShadow;
  logic [14:0] mAct;
  logic s1de, s1hs, s1vs, s2de, s2hs, s2vs, mFilt, mPrev, pend, eValid;
  logic [15:0] s1d, eData;
  logic [7:0] hi;
  logic [2:0] mCnt;

  always @(posedge clk) begin
    logic en, two, sw, outPre, rise, emit, ld;
    logic [15:0] w;
    if (!rst_n) begin
      mShadow = 32'hA8; mAct = 15'hA8;
      {s1de, s1hs, s1vs, s2de, s2hs, s2vs, mFilt, mPrev, pend, eValid} = '0;
      s1d = '0; eData = '0; hi = '0; mCnt = '0;
    end else begin
      en = mAct[14]; two = mAct[1]; sw = mAct[0];
      outPre = en ? mFilt : s2vs;
      rise = outPre & ~mPrev;
      mPrev = outPre;
      if (!en) begin mFilt = s1vs; mCnt = 0; end
      else if (s1vs == mFilt) mCnt = 0;
      else if (mCnt >= mAct[13:11]) begin mFilt = s1vs; mCnt = 0; end
      else mCnt = mCnt + 3'd1;
      emit = s1de & (two | pend);
      ld   = s1de & ~two & ~pend;
      eValid = emit;
      if (emit) begin
        w = two ? s1d : {hi, s1d[7:0]};
        eData = sw ? {w[7:0], w[15:8]} : w;
      end
      if (ld) hi = s1d[7:0];
      pend = ld;
      s2de = s1de; s2hs = s1hs; s2vs = s1vs;
      s1de = pixDe ^ mAct[8]; s1hs = pixHsync ^ mAct[9]; s1vs = pixVsync ^ mAct[10];
      s1d = pixData;
      if (rise) mAct = mShadow[14:0];
      if (cfgWrEn) mShadow = cfgWrData;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic expV;
    expV = mAct[14] ? mFilt : s2vs;
    check("R4 de", {31'd0, outDe}, {31'd0, s2de});
    check("R4 hsync", {31'd0, outHsync}, {31'd0, s2hs});
    check(mAct[14] ? "R6 vsync" : "R5 vsync", {31'd0, outVsync}, {31'd0, expV});
    check(mAct[1] ? "R7 valid" : "R8 valid", {31'd0, outValid}, {31'd0, eValid});
    if (eValid) check(mAct[0] ? "R9 data" : (mAct[1] ? "R7 data" : "R8 data"),
                      {16'd0, outData}, {16'd0, eData});
    check("R11 tag", {26'd0, outType}, {26'd0, mAct[7:2]});
    if (outValid) check("R10 valid needs de", {31'd0, outDe}, 32'd1);
  endtask

  int validSeen = 0;
  bit vsSeen = 1'b0;
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    if (outValid) validSeen++;
    if (outVsync) vsSeen = 1'b1;
  endtask

  logic curDeInv = 1'b0, curHsInv = 1'b0, curVsInv = 1'b0;

  task automatic writeCfg(input logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
    check("R2 readback", cfgRdData, v);
  endtask

  task automatic activate(input logic [31:0] v);
    pixVsync = curVsInv;
    repeat (12) tick();
    pixVsync = ~curVsInv;
    repeat (12) tick();
    curDeInv = v[8]; curHsInv = v[9]; curVsInv = v[10];
    pixDe = curDeInv; pixHsync = curHsInv; pixVsync = curVsInv;
    repeat (12) tick();
    check("R3 commit", {26'd0, outType}, {26'd0, v[7:2]});
  endtask

  task automatic line(input int n, input bit two);
    validSeen = 0;
    pixHsync = ~curHsInv;
    for (int i = 0; i < n; i++) begin
      pixDe = ~curDeInv;
      pixData = 16'($urandom);
      if ($urandom_range(0, 3) == 0) pixHsync = curHsInv;
      tick();
    end
    pixDe = curDeInv; pixHsync = curHsInv;
    repeat (4) tick();
    check(two ? "R7 word count" : "R8 word count", validSeen, two ? n : n / 2);
  endtask

  task automatic glitch(input int len, input bit expectEdge, input string tag);
    vsSeen = 1'b0;
    pixVsync = ~curVsInv;
    repeat (len) tick();
    pixVsync = curVsInv;
    repeat (14) tick();
    check(tag, {31'd0, vsSeen}, {31'd0, expectEdge});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 readback", cfgRdData, 32'h0000_00A8);
    check("R1 tag", {26'd0, outType}, 32'h2A);
    check("R1 valid", {31'd0, outValid}, 32'd0);
    tick();

    // Default: one byte per clock, odd lines drop the trailing byte.
    line(5, 0); line(6, 0); line(1, 0); line(8, 0);

    // Two bytes per clock, swap, inverted enable, RAW10 tag.
    writeCfg(32'h0000_01AF);
    repeat (3) tick();
    check("R3 staged", {26'd0, outType}, 32'h2A);
    activate(32'h0000_01AF);
    for (int i = 0; i < 6; i++) line($urandom_range(1, 9), 1);

    // One byte, swap, inverted line/frame sync, filter T=3, unlisted tag.
    writeCfg(32'h0000_5FFD);
    activate(32'h0000_5FFD);
    for (int i = 0; i < 4; i++) line($urandom_range(1, 9), 0);
    glitch(3, 1'b0, "R6 bounce T=3 len3");
    glitch(4, 1'b1, "R6 edge T=3 len4");
    glitch(1, 1'b0, "R6 bounce T=3 len1");

    // Two bytes, filter T=7, RAW12, upper bits kept for readback.
    writeCfg(32'hABCD_78B2);
    activate(32'hABCD_78B2);
    glitch(7, 1'b0, "R6 bounce T=7 len7");
    glitch(8, 1'b1, "R6 edge T=7 len8");
    for (int i = 0; i < 4; i++) line($urandom_range(1, 9), 1);

    // One byte, filter T=0.
    writeCfg(32'h0000_40A8);
    activate(32'h0000_40A8);
    glitch(1, 1'b1, "R6 edge T=0 len1");
    for (int i = 0; i < 20; i++) line($urandom_range(1, 12), 0);

    // Back to unfiltered with random vsync wiggles checked by the model.
    writeCfg(32'h0000_00A9);
    activate(32'h0000_00A9);
    for (int i = 0; i < 30; i++) begin
      pixVsync = 1'($urandom);
      tick();
    end
    pixVsync = curVsInv;
    repeat (5) tick();

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nChk++; nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

endmodule